// File: doc/BRIEF.md
# Interprocessor and Timer Interrupt Register

This block keeps, for each of up to four processors, one pending bit for an interprocessor interrupt and one for an interval-timer interrupt. It drives each pending bit out as a registered interrupt line. Software reaches the block through a simple single-cycle register access port that selects one of four registers.

The control register packs three per-processor fields into one write. One field requests interprocessor interrupts, one clears them, and one clears timer interrupts. Two more registers read the interprocessor and timer pending sets directly, and a write to either of them clears the bits set in the written mask. A fourth register sets interprocessor pending bits from a written mask.

A one-cycle tick input marks a timer interrupt pending on every configured processor. Misused operations are not acted on. They are reported on a warning pulse (a redundant request, or a clear of an idle processor) or on an error pulse (an empty mask, or an unsupported control write).

Top module: `ipi_timer_intr`

## Requirements
- R1: While reset is asserted, every pending bit, every interrupt output, `warn` and `err` are cleared to 0.
- R2: A control write (`acc_sel`=0) sets interprocessor pending for processor i when bit 12+i of the data is 1. The matching `ipi_irq` bit is high from the second clock edge after the write.
- R3: In a control write, bit 8+i clears interprocessor pending for processor i, and bit 4+i clears timer pending for processor i.
- R4: A control write whose bits 15:4 are all zero is accepted without error and without any state change when bit 28 is 1. When bit 28 is 0, the same write pulses `err` for one cycle after the write.
- R5: A read returns `rd_valid` one cycle after the request. A control read returns interprocessor pending in bits 8+i, timer pending in bits 4+i, and `acc_cpu` in bits 1:0, with every other bit 0.
- R6: A request for a processor already pending, or a clear for a processor not pending, leaves that bit unchanged and pulses `warn` for one cycle after the write. State before the access is the reference.
- R7: A cycle with `tick` high makes timer pending 1 for every configured processor.
- R8: Register 1 reads interprocessor pending in bits i, and a write to it clears pending where data bit i is 1. Register 2 does the same for timer pending. A write to register 3 sets interprocessor pending where data bit i is 1, and a read of register 3 returns 0.
- R9: A write to register 1, 2 or 3 whose data bits 3:0 are all zero pulses `err` and changes no state. Mask bits at or above NCPU are ignored.
- R10: When a set and a clear hit the same bit in one cycle, the set wins. This covers a tick together with a timer clear, and a control request together with a control clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Register access this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 2 | Register: 0 control, 1 IPI pending, 2 timer pending, 3 IPI set |
| acc_wdata | input | 32 | Write data |
| acc_cpu | input | 2 | Identifier of the accessing processor |
| tick | input | 1 | Interval-timer tick |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| ipi_irq | output | NCPU | Interprocessor interrupt per processor |
| tmr_irq | output | NCPU | Timer interrupt per processor |
| warn | output | 1 | Redundant request or clear of an idle processor |
| err | output | 1 | Empty mask or unsupported control write |

## Verification
The bench repeats a request to a processor that is already pending and clears a processor that is idle. A design that toggled the bits instead of setting and clearing them would flip state here and stay silent on `warn`. It writes a control word carrying only bit 28, and then one with no bits at all, so an inverted or missing acceptance test shows up as a wrong `err` pulse or as disturbed pending bits. It also drives a tick in the same cycle as a timer clear, and a request in the same cycle as a clear, where a design with the wrong priority would leave the bit at 0. Control reads issued from several processor identifiers catch a misplaced field or a dropped identifier.

// File: rtl/ipi_timer_intr.sv
module ipi_timer_intr #(
  parameter int NCPU = 4,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_valid,
  input  logic            acc_write,
  input  logic [1:0]      acc_sel,
  input  logic [DW-1:0]   acc_wdata,
  input  logic [1:0]      acc_cpu,
  input  logic            tick,
  output logic            rd_valid,
  output logic [DW-1:0]   rd_data,
  output logic [NCPU-1:0] ipi_irq,
  output logic [NCPU-1:0] tmr_irq,
  output logic            warn,
  output logic            err
);
  localparam int FW = 4;
  localparam int ACCEPT_BIT = 28;

  logic [NCPU-1:0] ipi_pend, tmr_pend;

  wire wr     = acc_valid & acc_write;
  wire rd     = acc_valid & ~acc_write;
  wire ctl_wr = wr & (acc_sel == 2'd0);
  wire ic_wr  = wr & (acc_sel == 2'd1);
  wire tc_wr  = wr & (acc_sel == 2'd2);
  wire is_wr  = wr & (acc_sel == 2'd3);

  wire [FW-1:0] f_req  = acc_wdata[15:12];
  wire [FW-1:0] f_iclr = acc_wdata[11:8];
  wire [FW-1:0] f_tclr = acc_wdata[7:4];
  wire [FW-1:0] f_mask = acc_wdata[FW-1:0];

  wire [FW-1:0] set_raw  = ctl_wr ? f_req  : (is_wr ? f_mask : '0);
  wire [FW-1:0] iclr_raw = ctl_wr ? f_iclr : (ic_wr ? f_mask : '0);
  wire [FW-1:0] tclr_raw = ctl_wr ? f_tclr : (tc_wr ? f_mask : '0);

  wire [NCPU-1:0] set_m  = set_raw[NCPU-1:0];
  wire [NCPU-1:0] iclr_m = iclr_raw[NCPU-1:0];
  wire [NCPU-1:0] tclr_m = tclr_raw[NCPU-1:0];

  wire [NCPU-1:0] ipi_next = (ipi_pend & ~iclr_m) | set_m;
  wire [NCPU-1:0] tmr_next = (tmr_pend & ~tclr_m) | {NCPU{tick}};

  wire warn_c = |(set_m & ipi_pend) | |(iclr_m & ~ipi_pend) | |(tclr_m & ~tmr_pend);
  wire ctl_empty = (f_req == '0) && (f_iclr == '0) && (f_tclr == '0);
  wire err_c = ctl_wr ? (ctl_empty & ~acc_wdata[ACCEPT_BIT])
                      : (wr & (f_mask == '0));

  logic [DW-1:0] rd_c;
  always_comb begin
    rd_c = '0;
    unique case (acc_sel)
      2'd0: begin
        rd_c[8 +: NCPU] = ipi_pend;
        rd_c[4 +: NCPU] = tmr_pend;
        rd_c[1:0]       = acc_cpu;
      end
      2'd1: rd_c[NCPU-1:0] = ipi_pend;
      2'd2: rd_c[NCPU-1:0] = tmr_pend;
      default: rd_c = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ipi_pend <= '0;
      tmr_pend <= '0;
      ipi_irq  <= '0;
      tmr_irq  <= '0;
      warn     <= 1'b0;
      err      <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      ipi_irq  <= ipi_pend;
      tmr_irq  <= tmr_pend;
      warn     <= wr & warn_c;
      err      <= err_c;
      rd_valid <= rd;
      if (rd) rd_data <= rd_c;
      if (err_c) begin
        tmr_pend <= tmr_pend | {NCPU{tick}};
      end else begin
        ipi_pend <= ipi_next;
        tmr_pend <= tmr_next;
      end
    end
  end
endmodule

module ipi_timer_intr_chk #(
  parameter int NCPU = 4,
  parameter int DW   = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            acc_valid,
  input logic            acc_write,
  input logic [1:0]      acc_sel,
  input logic [DW-1:0]   acc_wdata,
  input logic            tick,
  input logic            rd_valid,
  input logic            err,
  input logic [NCPU-1:0] ipi_irq,
  input logic [NCPU-1:0] tmr_irq,
  input logic [NCPU-1:0] ipi_pend,
  input logic [NCPU-1:0] tmr_pend
);
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (ipi_irq == '0 && tmr_irq == '0 && ipi_pend == '0 && tmr_pend == '0));

  p_tick_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (tmr_pend == {NCPU{1'b1}}));

  p_read_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write) |=> rd_valid);

  p_empty_mask_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_sel != 2'd0 && acc_wdata[3:0] == 4'd0)
      |=> (err && $stable(ipi_pend)));

  p_accept_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_sel == 2'd0 && acc_wdata[15:4] == 12'd0 && acc_wdata[28])
      |=> (!err && $stable(ipi_pend)));
endmodule

bind ipi_timer_intr ipi_timer_intr_chk #(.NCPU(NCPU), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_sel(acc_sel), .acc_wdata(acc_wdata), .tick(tick), .rd_valid(rd_valid),
  .err(err), .ipi_irq(ipi_irq), .tmr_irq(tmr_irq),
  .ipi_pend(ipi_pend), .tmr_pend(tmr_pend)
);

// File: tb/tb_ipi_timer_intr.sv
module tb_ipi_timer_intr;
  localparam int NCPU = 4;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0, acc_write = 1'b0, tick = 1'b0;
  logic [1:0] acc_sel = '0, acc_cpu = '0;
  logic [DW-1:0] acc_wdata = '0;
  logic rd_valid, warn, err;
  logic [DW-1:0] rd_data;
  logic [NCPU-1:0] ipi_irq, tmr_irq;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [DW-1:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  ipi_timer_intr #(.NCPU(NCPU), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_sel(acc_sel), .acc_wdata(acc_wdata), .acc_cpu(acc_cpu), .tick(tick),
    .rd_valid(rd_valid), .rd_data(rd_data), .ipi_irq(ipi_irq), .tmr_irq(tmr_irq),
    .warn(warn), .err(err)
  );

  task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R5: actual unexpected response %h expected none", rd_data);
      end else begin
        chk(rd_data, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [DW-1:0] d, input logic tk);
    @(negedge clk);
    acc_valid = 1; acc_write = 1; acc_sel = sel; acc_wdata = d; tick = tk;
    @(negedge clk);
    acc_valid = 0; acc_write = 0; tick = 0;
  endtask

  task automatic rd(input logic [1:0] sel, input logic [1:0] cpu,
                    input logic [DW-1:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    acc_valid = 1; acc_write = 0; acc_sel = sel; acc_cpu = cpu;
    @(negedge clk);
    acc_valid = 0;
    @(negedge clk);
  endtask

  task automatic flags(input logic w, input logic e, input string tag);
    chk({30'd0, warn, err}, {30'd0, w, e}, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({24'd0, ipi_irq, tmr_irq}, 32'd0, "R1 irq in reset");
    flags(0, 0, "R1 flags in reset");
    rst_n = 1;
    rd(2'd0, 2'd2, 32'h2, "R5 ctrl read after reset");

    wr(2'd0, 32'h5000, 0);
    flags(0, 0, "R2 request flags");
    chk({28'd0, ipi_irq}, 32'd0, "R2 irq not yet");
    @(negedge clk);
    chk({28'd0, ipi_irq}, 32'h5, "R2 irq after request");
    rd(2'd1, 2'd0, 32'h5, "R8 ipi pending read");
    rd(2'd0, 2'd1, 32'h501, "R5 ctrl read cpu1");

    wr(2'd0, 32'h1000, 0);
    flags(1, 0, "R6 redundant request warn");
    rd(2'd1, 2'd0, 32'h5, "R6 state unchanged");

    wr(2'd0, 32'h0400, 0);
    flags(0, 0, "R3 ipi clear flags");
    @(negedge clk);
    chk({28'd0, ipi_irq}, 32'h1, "R3 ipi cleared");
    wr(2'd0, 32'h0400, 0);
    flags(1, 0, "R6 clear idle warn");

    wr(2'd0, 32'h1000_0000, 1);
    flags(0, 0, "R4 accept-only no err");
    @(negedge clk);
    chk({28'd0, tmr_irq}, 32'hF, "R7 tick all timers");
    rd(2'd2, 2'd0, 32'hF, "R7 timer pending read");

    wr(2'd0, 32'h0030, 0);
    rd(2'd0, 2'd3, 32'h1C3, "R3 timer clear via ctrl");

    wr(2'd0, 32'h1000_0000, 0);
    flags(0, 0, "R4 bit28 accepted");
    rd(2'd0, 2'd0, 32'h1C0, "R4 no change");
    wr(2'd0, 32'h0, 0);
    flags(0, 1, "R4 empty ctrl err");

    wr(2'd3, 32'h6, 0);
    rd(2'd1, 2'd0, 32'h7, "R8 set register");
    wr(2'd1, 32'h3, 0);
    rd(2'd1, 2'd0, 32'h4, "R8 ipi clear register");
    wr(2'd2, 32'h4, 0);
    rd(2'd2, 2'd0, 32'h8, "R8 timer clear register");
    rd(2'd3, 2'd0, 32'h0, "R8 set register reads zero");

    wr(2'd3, 32'hF0, 0);
    flags(0, 1, "R9 empty set mask err");
    wr(2'd1, 32'h0, 0);
    flags(0, 1, "R9 empty clear mask err");
    rd(2'd1, 2'd0, 32'h4, "R9 state unchanged");

    wr(2'd2, 32'hF, 1);
    rd(2'd2, 2'd0, 32'hF, "R10 tick beats timer clear");
    wr(2'd0, 32'h1100, 0);
    rd(2'd1, 2'd0, 32'h5, "R10 request beats clear");

    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL R5: actual %0d responses missing expected 0", exp_q.size());
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule